// File: doc/BRIEF.md
# Sleep and Reset Control Registers

This block sits on a simple I/O bus and holds three small registers used by platform power management: a byte-wide reset register, a 16-bit sleep control register and a write-only command port. Each bus cycle carries an address, an access size in bytes, a read strobe, a write strobe and write data. An access whose size does not match the register it addresses is dropped.

Software asks for a system reset by writing the reset register with its go bit set. It asks for soft power-off by writing the sleep control register with the sleep-go bit set and sleep type 5. The ACPI-enable bit (bit 0 of the sleep control register) belongs to the command port: one command code sets it and another clears it. A direct write to the control register never changes it. The block drives that bit out as a level for the event logic, and issues the reset and power-off requests as single-cycle pulses.

Top module: `slpctl_regs`

## Requirements
- R1: After reset, both registers read as zero, and the ACPI-enable level, the reset request, the power-off request and the read data are all low.
- R2: The reset register sits at address 0x0CF9 and responds only to 1-byte accesses. Any other size has no effect and reads back zero.
- R3: A 1-byte read of the reset register returns all 8 bits of the last value written to it.
- R4: A 1-byte write to the reset register with bit 2 set raises the reset request in the cycle after the write. Bit 1 (soft or hard) makes no difference. A write with bit 2 clear raises no request.
- R5: The sleep control register sits at address 0x0404 and responds only to 2-byte accesses. Any other size has no effect and reads back zero.
- R6: A write to the sleep control register stores bits 12:2. Bits 15:13 and bit 1 always read as zero, and bit 0 keeps its previous value.
- R7: A write to the sleep control register with bit 13 set and bits 12:10 equal to 5 raises the power-off request in the cycle after the write. Any other combination raises no request.
- R8: A 1-byte write of code 0xA0 to the command port at address 0x00B2 sets the ACPI-enable bit, and code 0xA1 clears it. Other codes and other sizes have no effect, and a read of the port returns zero.
- R9: Each request output stays high for exactly one cycle. A qualifying write that arrives while that output is high is absorbed and gives no second pulse.
- R10: Read data appears in the cycle after the read strobe and is zero in every other cycle. When read and write hit the same register in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the access |
| io_size | input | 3 | Access size in bytes |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, registered |
| rst_req | output | 1 | One-cycle system reset request |
| off_req | output | 1 | One-cycle soft power-off request |
| acpi_on | output | 1 | ACPI-enable level |

## Verification
Two things can land in the same cycle. The first is a new qualifying write while the previous request pulse is still high. The bench provokes it with back-to-back reset writes and back-to-back power-off writes, and expects exactly one pulse from each pair. The second is a read and a write to the same register in one cycle. The bench raises both strobes together on each register and expects the old contents on the read data, with the new contents visible on the next read. A behavioural model, built on the requirements alone, predicts every output in every cycle, and the bench compares it against the design.

// File: rtl/slpctl_pkg.sv
package slpctl_pkg;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_RST  = 2'd1,
      TGT_CTL  = 2'd2,
      TGT_CMD  = 2'd3
   } tgt_e;

   localparam int CTL_W      = 16;
   localparam int RST_W      = 8;
   localparam int GO_BIT     = 2;
   localparam int SLPEN_BIT  = 13;
   localparam int TYPE_LO    = 10;
   localparam int TYPE_W     = 3;
   localparam int OFF_TYPE   = 5;

   // bits kept by a control write: TYPE field down to bit 2
   localparam logic [CTL_W-1:0] CTL_KEEP =
      CTL_W'((1 << SLPEN_BIT) - 1) & ~CTL_W'(3);
   localparam logic [CTL_W-1:0] OFF_MASK =
      CTL_W'((1 << SLPEN_BIT) | (((1 << TYPE_W) - 1) << TYPE_LO));
   localparam logic [CTL_W-1:0] OFF_MATCH =
      CTL_W'((1 << SLPEN_BIT) | (OFF_TYPE << TYPE_LO));

endpackage

// File: rtl/slpctl_decode.sv
module slpctl_decode
   import slpctl_pkg::*;
#(
   parameter int              ADDR_W   = 16,
   parameter int              SIZE_W   = 3,
   parameter logic [ADDR_W-1:0] RST_PORT = 16'h0CF9,
   parameter logic [ADDR_W-1:0] CTL_PORT = 16'h0404,
   parameter logic [ADDR_W-1:0] CMD_PORT = 16'h00B2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output tgt_e              tgt
);
   localparam logic [SIZE_W-1:0] SZ_BYTE = SIZE_W'(RST_W / 8);
   localparam logic [SIZE_W-1:0] SZ_WORD = SIZE_W'(CTL_W / 8);

   always_comb begin
      tgt = TGT_NONE;
      if (addr == RST_PORT && size == SZ_BYTE)      tgt = TGT_RST;
      else if (addr == CTL_PORT && size == SZ_WORD) tgt = TGT_CTL;
      else if (addr == CMD_PORT && size == SZ_BYTE) tgt = TGT_CMD;
   end
endmodule

// File: rtl/slpctl_pulse.sv
module slpctl_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= fire & ~pulse;
   end
endmodule

// File: rtl/slpctl_rstreg.sv
module slpctl_rstreg
   import slpctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [RST_W-1:0] wdata,
   output logic [RST_W-1:0] val,
   output logic             go_fire
);
   always_ff @(posedge clk) begin
      if (!rst_n)     val <= '0;
      else if (wr_en) val <= wdata;
   end

   // soft and hard selections lead to the same request
   assign go_fire = wr_en & wdata[GO_BIT];
endmodule

// File: rtl/slpctl_ctlreg.sv
module slpctl_ctlreg
   import slpctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wdata,
   input  logic             acpi_set,
   input  logic             acpi_clr,
   output logic [CTL_W-1:0] val,
   output logic             off_fire
);
   logic [CTL_W-1:1] body;
   logic             acpi_bit;
   logic [CTL_W-1:0] kept;

   assign kept = wdata & CTL_KEEP;

   always_ff @(posedge clk) begin
      if (!rst_n)     body <= '0;
      else if (wr_en) body <= kept[CTL_W-1:1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        acpi_bit <= 1'b0;
      else if (acpi_set) acpi_bit <= 1'b1;
      else if (acpi_clr) acpi_bit <= 1'b0;
   end

   assign val      = {body, acpi_bit};
   assign off_fire = wr_en && ((wdata & OFF_MASK) == OFF_MATCH);
endmodule

// File: rtl/slpctl_regs.sv
module slpctl_regs
   import slpctl_pkg::*;
#(
   parameter int                ADDR_W   = 16,
   parameter int                SIZE_W   = 3,
   parameter int                DATA_W   = 16,
   parameter logic [ADDR_W-1:0] RST_PORT = 16'h0CF9,
   parameter logic [ADDR_W-1:0] CTL_PORT = 16'h0404,
   parameter logic [ADDR_W-1:0] CMD_PORT = 16'h00B2,
   parameter logic [7:0]        CMD_ON   = 8'hA0,
   parameter logic [7:0]        CMD_OFF  = 8'hA1,
   parameter int                RD_LAT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [SIZE_W-1:0] io_size,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              rst_req,
   output logic              off_req,
   output logic              acpi_on
);
   if (DATA_W < CTL_W) begin : g_bad_data_w
      $error("slpctl_regs: DATA_W must be at least the control width");
   end
   if (RD_LAT != 0 && RD_LAT != 1) begin : g_bad_rd_lat
      $error("slpctl_regs: RD_LAT must be 0 or 1");
   end
   if (CMD_ON == CMD_OFF) begin : g_bad_cmd
      $error("slpctl_regs: command codes must differ");
   end
   if (SIZE_W < 2) begin : g_bad_size_w
      $error("slpctl_regs: SIZE_W too small for a 2-byte size");
   end

   tgt_e             tgt;
   logic             wr_rst, wr_ctl, wr_cmd;
   logic [RST_W-1:0] rst_val;
   logic [CTL_W-1:0] ctl_val;
   logic             go_fire, off_fire;
   logic             acpi_set, acpi_clr;
   logic [DATA_W-1:0] rd_val;

   slpctl_decode #(
      .ADDR_W  (ADDR_W),
      .SIZE_W  (SIZE_W),
      .RST_PORT(RST_PORT),
      .CTL_PORT(CTL_PORT),
      .CMD_PORT(CMD_PORT)
   ) u_decode (
      .addr(io_addr),
      .size(io_size),
      .tgt (tgt)
   );

   assign wr_rst = io_wr && tgt == TGT_RST;
   assign wr_ctl = io_wr && tgt == TGT_CTL;
   assign wr_cmd = io_wr && tgt == TGT_CMD;

   assign acpi_set = wr_cmd && io_wdata[7:0] == CMD_ON;
   assign acpi_clr = wr_cmd && io_wdata[7:0] == CMD_OFF;

   slpctl_rstreg u_rstreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_rst),
      .wdata  (io_wdata[RST_W-1:0]),
      .val    (rst_val),
      .go_fire(go_fire)
   );

   slpctl_ctlreg u_ctlreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ctl),
      .wdata   (io_wdata[CTL_W-1:0]),
      .acpi_set(acpi_set),
      .acpi_clr(acpi_clr),
      .val     (ctl_val),
      .off_fire(off_fire)
   );

   slpctl_pulse u_rst_pulse (
      .clk  (clk),
      .rst_n(rst_n),
      .fire (go_fire),
      .pulse(rst_req)
   );

   slpctl_pulse u_off_pulse (
      .clk  (clk),
      .rst_n(rst_n),
      .fire (off_fire),
      .pulse(off_req)
   );

   assign acpi_on = ctl_val[0];

   always_comb begin
      rd_val = '0;
      if (io_rd) begin
         case (tgt)
            TGT_RST: rd_val[RST_W-1:0] = rst_val;
            TGT_CTL: rd_val[CTL_W-1:0] = ctl_val;
            default: rd_val = '0;
         endcase
      end
   end

   if (RD_LAT == 1) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) io_rdata <= '0;
         else        io_rdata <= rd_val;
      end
   end else begin : g_rd_comb
      assign io_rdata = rd_val;
   end
endmodule

// File: rtl/slpctl_chk.sv
module slpctl_chk #(
   parameter int                ADDR_W   = 16,
   parameter int                SIZE_W   = 3,
   parameter int                DATA_W   = 16,
   parameter logic [ADDR_W-1:0] RST_PORT = 16'h0CF9,
   parameter logic [ADDR_W-1:0] CTL_PORT = 16'h0404,
   parameter logic [ADDR_W-1:0] CMD_PORT = 16'h00B2,
   parameter logic [7:0]        CMD_ON   = 8'hA0,
   parameter logic [7:0]        CMD_OFF  = 8'hA1,
   parameter int                RD_LAT   = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic [SIZE_W-1:0] io_size,
   input logic              io_rd,
   input logic              io_wr,
   input logic [DATA_W-1:0] io_wdata,
   input logic [DATA_W-1:0] io_rdata,
   input logic              rst_req,
   input logic              off_req,
   input logic              acpi_on
);
   localparam logic [DATA_W-1:0] GO_MASK   = DATA_W'(16'h0004);
   localparam logic [DATA_W-1:0] OFF_MASK  = DATA_W'(16'h3C00);
   localparam logic [DATA_W-1:0] OFF_MATCH = DATA_W'(16'h3400);
   localparam logic [DATA_W-1:0] BYTE_MASK = DATA_W'(16'h00FF);

   logic byte_rst_wr, word_ctl_wr, byte_cmd_wr;
   assign byte_rst_wr = io_wr && io_addr == RST_PORT && io_size == SIZE_W'(1);
   assign word_ctl_wr = io_wr && io_addr == CTL_PORT && io_size == SIZE_W'(2);
   assign byte_cmd_wr = io_wr && io_addr == CMD_PORT && io_size == SIZE_W'(1);

   // R4
   rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(byte_rst_wr && (io_wdata & GO_MASK) != '0));

   // R7
   off_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_req |-> $past(word_ctl_wr && (io_wdata & OFF_MASK) == OFF_MATCH));

   // R9
   rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   // R9
   off_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_req |=> !off_req);

   // R8
   acpi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acpi_on) |-> $past(byte_cmd_wr && (io_wdata & BYTE_MASK) == DATA_W'(CMD_ON)));

   // R8
   acpi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(acpi_on) |-> $past(byte_cmd_wr && (io_wdata & BYTE_MASK) == DATA_W'(CMD_OFF)));

   if (RD_LAT == 1) begin : g_rd_chk
      // R10
      rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(io_rd) |-> io_rdata == '0);
   end
endmodule

bind slpctl_regs slpctl_chk #(
   .ADDR_W  (ADDR_W),
   .SIZE_W  (SIZE_W),
   .DATA_W  (DATA_W),
   .RST_PORT(RST_PORT),
   .CTL_PORT(CTL_PORT),
   .CMD_PORT(CMD_PORT),
   .CMD_ON  (CMD_ON),
   .CMD_OFF (CMD_OFF),
   .RD_LAT  (RD_LAT)
) u_chk (.*);

// File: tb/test_slpctl_regs.sv
`timescale 1ns/1ps
module test_slpctl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [2:0]  io_size = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic [15:0] io_wdata = '0;
   logic [15:0] io_rdata;
   logic        rst_req, off_req, acpi_on;

   int n_chk = 0;
   int n_fail = 0;
   string tag = "R1";

   // reference model state
   int m_rst = 0;
   int m_ctl = 0;
   int m_rdata = 0;
   int m_rp = 0;
   int m_op = 0;

   localparam int A_RST = 'h0CF9;
   localparam int A_CTL = 'h0404;
   localparam int A_CMD = 'h00B2;

   always #5 clk = ~clk;

   slpctl_regs i_slpctl_regs (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
      .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .rst_req(rst_req), .off_req(off_req), .acpi_on(acpi_on)
   );

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("io_rdata", int'(io_rdata), m_rdata);
      chk("rst_req", int'(rst_req), m_rp);
      chk("off_req", int'(off_req), m_op);
      chk("acpi_on", int'(acpi_on), m_ctl & 1);
   endtask

   // one bus cycle: drive at negedge, model at posedge, compare at next negedge
   task automatic step(input bit rd, input bit wr, input int addr, input int sz,
                       input int wd);
      int  rv;
      bit  fr, fo;
      io_rd = rd; io_wr = wr; io_addr = 16'(addr); io_size = 3'(sz);
      io_wdata = 16'(wd);
      @(posedge clk);
      rv = 0; fr = 0; fo = 0;
      if (rd) begin
         if (addr == A_RST && sz == 1) rv = m_rst;
         else if (addr == A_CTL && sz == 2) rv = m_ctl;
      end
      if (wr) begin
         if (addr == A_RST && sz == 1) begin
            m_rst = wd & 'hFF;
            fr = ((wd >> 2) & 1) == 1;
         end else if (addr == A_CTL && sz == 2) begin
            fo = ((wd >> 13) & 1) == 1 && ((wd >> 10) & 7) == 5;
            m_ctl = (wd & 'h1FFC) | (m_ctl & 1);
         end else if (addr == A_CMD && sz == 1) begin
            if ((wd & 'hFF) == 'hA0) m_ctl = m_ctl | 1;
            else if ((wd & 'hFF) == 'hA1) m_ctl = m_ctl & ~1;
         end
      end
      m_rdata = rv;
      m_rp = (fr && m_rp == 0) ? 1 : 0;
      m_op = (fo && m_op == 0) ? 1 : 0;
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      tag = "R1";
      compare_all();
      rst_n = 1'b1;
      idle();
      step(1, 0, A_RST, 1, 0);
      step(1, 0, A_CTL, 2, 0);
      idle();

      // R3 / R4: reset register store and request
      tag = "R4";
      step(0, 1, A_RST, 1, 'h06);        // hard
      idle();
      step(0, 1, A_RST, 1, 'h04);        // soft
      idle();
      step(0, 1, A_RST, 1, 'h02);        // no go bit
      tag = "R3";
      step(1, 0, A_RST, 1, 0);
      idle();
      step(0, 1, A_RST, 1, 'hA9);
      step(1, 0, A_RST, 1, 0);
      idle();

      // R2: wrong sizes ignored
      tag = "R2";
      step(0, 1, A_RST, 2, 'h00FF);
      step(0, 1, A_RST, 4, 'h0004);
      step(1, 0, A_RST, 1, 0);
      step(1, 0, A_RST, 2, 0);
      idle();

      // R9: back-to-back reset writes absorbed
      tag = "R9";
      step(0, 1, A_RST, 1, 'h04);
      step(0, 1, A_RST, 1, 'h04);
      step(0, 1, A_RST, 1, 'h04);
      idle();
      idle();

      // R6: control store masks
      tag = "R6";
      step(0, 1, A_CTL, 2, 'hFFFF);
      step(1, 0, A_CTL, 2, 0);
      step(0, 1, A_CTL, 2, 'h0003);
      step(1, 0, A_CTL, 2, 0);
      idle();

      // R8: command port
      tag = "R8";
      step(0, 1, A_CMD, 1, 'hA0);
      step(1, 0, A_CTL, 2, 0);
      step(1, 0, A_CMD, 1, 0);
      step(0, 1, A_CMD, 1, 'h55);
      step(0, 1, A_CMD, 2, 'h00A1);
      tag = "R6";
      step(0, 1, A_CTL, 2, 'h0000);      // ACPI bit must survive
      step(1, 0, A_CTL, 2, 0);
      tag = "R8";
      step(0, 1, A_CMD, 1, 'hA1);
      step(1, 0, A_CTL, 2, 0);
      step(0, 1, A_CMD, 1, 'hA0);
      idle();

      // R7: power-off
      tag = "R7";
      step(0, 1, A_CTL, 2, 'h3400);
      step(1, 0, A_CTL, 2, 0);
      step(0, 1, A_CTL, 2, 'h1400);      // no sleep-go
      step(0, 1, A_CTL, 2, 'h2C00);      // type 3
      step(0, 1, A_CTL, 2, 'h3C00);      // type 7
      idle();
      tag = "R5";
      step(0, 1, A_CTL, 1, 'h3400);
      step(0, 1, A_CTL, 4, 'h3400);
      step(1, 0, A_CTL, 1, 0);
      step(1, 0, A_CTL, 2, 0);
      idle();
      tag = "R9";
      step(0, 1, A_CTL, 2, 'h3400);
      step(0, 1, A_CTL, 2, 'h3400);
      step(0, 1, A_CTL, 2, 'h3400);
      idle();

      // R10: read and write in the same cycle
      tag = "R10";
      step(1, 1, A_RST, 1, 'h5A);
      step(1, 0, A_RST, 1, 0);
      step(1, 1, A_CTL, 2, 'h0820);
      step(1, 0, A_CTL, 2, 0);
      idle();
      idle();

      summary();
      $finish;
   end
endmodule